// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block is a hardware master that configures a downstream FPGA through its byte-wide slave parallel configuration port. A host pulses `start_i` with the number of configuration bytes. The loader then pulses the active-low program line and waits for the device to clear its configuration memory. It selects the port, lets it settle, and clocks the bytes in one at a time from a valid/ready byte stream. At the end it polls the device's completion lines and reports either a one-cycle `ok_o` pulse or a one-cycle `fail_o` pulse with a 3-bit reason code.

The byte stream follows the usual valid/ready rules. A byte moves only on a clock edge where `s_valid_i` and `s_ready_o` are both high. A source that has raised `s_valid_i` keeps the same byte on `s_data_i` until that byte is taken. The loader applies back-pressure by holding `s_ready_o` low at the following times:
- while it is clocking the previous byte into the device;
- while it is waiting for the device's busy line;
- whenever the device reports completion or an error.

The byte count is latched when `start_i` is accepted, so later changes to `nbytes_i` have no effect on the cycle in progress. All delays and timeouts are parameters counted in system clock cycles, and the configuration-clock half period is one of them.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset the loader idles with `prog_n_o`, `cs_n_o`, `wr_n_o` and `cclk_o` high, `d_o` zero, `s_ready_o` low, and no `ok_o` or `fail_o` pulse.
- R2: A `start_i` seen in idle drives `prog_n_o` low for at least PROG_CYC cycles. It stays low until `init_n_i` is sampled low. If `init_n_i` is not seen low within INIT_LO_TMO cycles after the minimum pulse, the cycle fails with reason 1.
- R3: Once `init_n_i` is low, `prog_n_o` is released and `cclk_o` is held high. The loader then waits for `init_n_i` to return high. If that takes longer than INIT_HI_TMO cycles, the cycle fails with reason 2.
- R4: When `init_n_i` returns high, `cs_n_o` and `wr_n_o` fall in the same cycle. SETTLE_CYC cycles pass before `s_ready_o` may rise.
- R5: An accepted byte appears on `d_o` in the same cycle that `cclk_o` falls. `cclk_o` stays low for CCLK_HALF cycles and then high for CCLK_HALF cycles. `d_o` changes at no other time except an abort.
- R6: If `done_i` is high when the next byte is due, loading ends early without error and moves on to the completion check.
- R7: If `init_n_i` is low when the next byte is due, the cycle fails with reason 3. `fail_idx_o` then holds the number of bytes already accepted.
- R8: With BUSY_CHECK set, after each high half-period the loader waits for `busy_i` to be low. If `busy_i` stays high for BUSY_TMO cycles, the cycle fails with reason 4.
- R9: After the last byte, `cs_n_o` rises one cycle before `wr_n_o`. The loader then waits up to DONE_TMO cycles for `done_i` and `init_n_i` to be high together, and reports `ok_o` if they are. Otherwise the cycle fails with reason 5. A zero byte count goes straight to this step.
- R10: `s_ready_o` is high only in the byte-fetch step, while bytes are still owed, `done_i` is low and `init_n_i` is high. Exactly the latched count of bytes is taken.
- R11: On any failure, `prog_n_o`, `cs_n_o`, `wr_n_o` and `cclk_o` go high and `d_o` goes to zero in the same cycle. `fail_o` pulses for one cycle with `reason_o` set, and the loader returns to idle.
- R12: `start_i` is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration cycle (sampled in idle only) |
| nbytes_i | input | CNT_W | Number of bytes to load, latched at start |
| s_valid_i | input | 1 | Byte stream valid |
| s_data_i | input | DW | Byte stream data |
| s_ready_o | output | 1 | Byte stream ready |
| prog_n_o | output | 1 | Active-low program (clear) line |
| cs_n_o | output | 1 | Active-low chip select |
| wr_n_o | output | 1 | Active-low write strobe |
| cclk_o | output | 1 | Configuration clock |
| d_o | output | DW | Configuration data bus |
| init_n_i | input | 1 | Active-low init / error line from the device |
| busy_i | input | 1 | Device busy, active high |
| done_i | input | 1 | Device configured, active high |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| reason_o | output | 3 | Failure reason: 1 init-assert, 2 init-release, 3 data error, 4 busy, 5 completion timeout |
| fail_idx_o | output | CNT_W | Bytes accepted before a data error |

## Verification
The main load is driven in several ways:
- a full stream with no gaps;
- a stream with periodic valid gaps;
- a load with short busy stalls;
- a zero-length load.

Together these tell apart handshake timing, clock-pulse timing and the count that ends the load. Separate runs keep the init line high or low forever, drop the init line after two bytes, raise done after two bytes, hold busy stuck high and never raise done. Each of these separates one abort path and its reason code from the others and from an early but legal finish. A start pulse with a new count in the middle of a load shows that the running cycle keeps its latched count.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_SETTLE,
    ST_FETCH,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_BUSY,
    ST_DESEL,
    ST_POLL
  } ld_state_t;

  typedef enum logic [2:0] {
    RSN_NONE    = 3'd0,
    RSN_INIT_LO = 3'd1,
    RSN_INIT_HI = 3'd2,
    RSN_DATA    = 3'd3,
    RSN_BUSY    = 3'd4,
    RSN_DONE    = 3'd5
  } ld_reason_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_ld_timer.sv
module cfg_ld_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  // Down counter: reloaded on phase entry, saturates at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_ld_bytecnt.sv
module cfg_ld_bytecnt #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic [CW-1:0] total_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  logic [CW-1:0] total_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      total_q <= total_i;
      cnt_q   <= '0;
    end else if (inc_i) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == total_q);
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfg_ld_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PROG_CYC    = 100,
  parameter int unsigned INIT_LO_TMO = 125_000_000,
  parameter int unsigned INIT_HI_TMO = 125_000_000,
  parameter int unsigned SETTLE_CYC  = 2_500_000,
  parameter int unsigned CCLK_HALF   = 2,
  parameter bit          BUSY_CHECK  = 1'b0,
  parameter int unsigned BUSY_TMO    = 1_250_000,
  parameter int unsigned DONE_TMO    = 50_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nbytes_i,
  input  logic             s_valid_i,
  input  logic [DW-1:0]    s_data_i,
  output logic             s_ready_o,
  output logic             prog_n_o,
  output logic             cs_n_o,
  output logic             wr_n_o,
  output logic             cclk_o,
  output logic [DW-1:0]    d_o,
  input  logic             init_n_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             ok_o,
  output logic             fail_o,
  output logic [2:0]       reason_o,
  output logic [CNT_W-1:0] fail_idx_o
);
  localparam int unsigned T_MAX = max_u(max_u(max_u(PROG_CYC, INIT_LO_TMO), max_u(INIT_HI_TMO, SETTLE_CYC)),
                                        max_u(max_u(CCLK_HALF, BUSY_TMO), DONE_TMO));
  localparam int unsigned TW = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  localparam logic [TW-1:0] LD_PROG   = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] LD_ILO    = TW'(INIT_LO_TMO - 1);
  localparam logic [TW-1:0] LD_IHI    = TW'(INIT_HI_TMO - 1);
  localparam logic [TW-1:0] LD_SETTLE = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] LD_HALF   = TW'(CCLK_HALF - 1);
  localparam logic [TW-1:0] LD_BUSY   = TW'(BUSY_TMO - 1);
  localparam logic [TW-1:0] LD_DONE   = TW'(DONE_TMO - 1);

  ld_state_t        st_q, nxt;
  ld_reason_t       abort_c, rsn_q;
  logic             tld, tz, take, last, busy_en;
  logic [TW-1:0]    tval;
  logic [CNT_W-1:0] cnt;
  logic             prog_q, cs_q, wr_q, cclk_q, ok_q, fail_q;
  logic [DW-1:0]    d_q;
  logic [CNT_W-1:0] idx_q;

  generate
    if (BUSY_CHECK) begin : g_busy_wait
      assign busy_en = 1'b1;
    end else begin : g_busy_skip
      assign busy_en = 1'b0;
    end
  endgenerate

  cfg_ld_timer #(.TW(TW)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tld),
    .val_i  (tval),
    .zero_o (tz)
  );

  cfg_ld_bytecnt #(.CW(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (st_q == ST_IDLE && start_i),
    .total_i (nbytes_i),
    .inc_i   (take),
    .cnt_o   (cnt),
    .last_o  (last)
  );

  assign s_ready_o = (st_q == ST_FETCH) && !last && !done_i && init_n_i;
  assign take      = s_ready_o && s_valid_i;

  always_comb begin
    nxt     = st_q;
    tld     = 1'b0;
    tval    = '0;
    abort_c = RSN_NONE;
    case (st_q)
      ST_IDLE:    if (start_i) begin nxt = ST_PULSE; tld = 1'b1; tval = LD_PROG; end
      ST_PULSE:   if (tz) begin nxt = ST_WAIT_LO; tld = 1'b1; tval = LD_ILO; end
      ST_WAIT_LO: begin
        if (!init_n_i) begin nxt = ST_WAIT_HI; tld = 1'b1; tval = LD_IHI; end
        else if (tz) abort_c = RSN_INIT_LO;
      end
      ST_WAIT_HI: begin
        if (init_n_i) begin nxt = ST_SETTLE; tld = 1'b1; tval = LD_SETTLE; end
        else if (tz) abort_c = RSN_INIT_HI;
      end
      ST_SETTLE:  if (tz) nxt = ST_FETCH;
      ST_FETCH: begin
        if (last || done_i)  nxt = ST_DESEL;
        else if (!init_n_i)  abort_c = RSN_DATA;
        else if (s_valid_i)  begin nxt = ST_CLK_LO; tld = 1'b1; tval = LD_HALF; end
      end
      ST_CLK_LO:  if (tz) begin nxt = ST_CLK_HI; tld = 1'b1; tval = LD_HALF; end
      ST_CLK_HI: begin
        if (tz) begin
          if (busy_en) begin nxt = ST_BUSY; tld = 1'b1; tval = LD_BUSY; end
          else nxt = ST_FETCH;
        end
      end
      ST_BUSY: begin
        if (!busy_i) nxt = ST_FETCH;
        else if (tz) abort_c = RSN_BUSY;
      end
      ST_DESEL:   begin nxt = ST_POLL; tld = 1'b1; tval = LD_DONE; end
      ST_POLL: begin
        if (done_i && init_n_i) nxt = ST_IDLE;
        else if (tz) abort_c = RSN_DONE;
      end
      default:    nxt = ST_IDLE;
    endcase
    if (abort_c != RSN_NONE) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b1;
      cs_q   <= 1'b1;
      wr_q   <= 1'b1;
      cclk_q <= 1'b1;
      d_q    <= '0;
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      rsn_q  <= RSN_NONE;
      idx_q  <= '0;
    end else begin
      st_q   <= nxt;
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      if (abort_c != RSN_NONE) begin
        prog_q <= 1'b1;
        cs_q   <= 1'b1;
        wr_q   <= 1'b1;
        cclk_q <= 1'b1;
        d_q    <= '0;
        fail_q <= 1'b1;
        rsn_q  <= abort_c;
        if (abort_c == RSN_DATA) idx_q <= cnt;
      end else begin
        case (st_q)
          ST_IDLE:    if (start_i) prog_q <= 1'b0;
          ST_WAIT_LO: if (!init_n_i) begin prog_q <= 1'b1; cclk_q <= 1'b1; end
          ST_WAIT_HI: if (init_n_i) begin cs_q <= 1'b0; wr_q <= 1'b0; end
          ST_FETCH: begin
            if (nxt == ST_DESEL) cs_q <= 1'b1;
            else if (take) begin d_q <= s_data_i; cclk_q <= 1'b0; end
          end
          ST_CLK_LO:  if (tz) cclk_q <= 1'b1;
          ST_DESEL:   wr_q <= 1'b1;
          ST_POLL:    if (nxt == ST_IDLE) ok_q <= 1'b1;
          default:    ;
        endcase
      end
    end
  end

  assign prog_n_o   = prog_q;
  assign cs_n_o     = cs_q;
  assign wr_n_o     = wr_q;
  assign cclk_o     = cclk_q;
  assign d_o        = d_q;
  assign ok_o       = ok_q;
  assign fail_o     = fail_q;
  assign reason_o   = rsn_q;
  assign fail_idx_o = idx_q;
endmodule

// File: rtl/cfg_ld_checker.sv
module cfg_ld_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prog_n_o,
  input logic          cs_n_o,
  input logic          wr_n_o,
  input logic          cclk_o,
  input logic [DW-1:0] d_o,
  input logic          ok_o,
  input logic          fail_o,
  input logic          s_ready_o,
  input logic          init_n_i,
  input logic          done_i
);
  // R2: while the clear pulse is driven the port is deselected and the clock idles high
  p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (cs_n_o && wr_n_o && cclk_o));

  // R4: select and write strobe fall together
  p_sel_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $fell(wr_n_o));

  // R5: the clock only pulses low with the port selected
  p_clk_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cclk_o |-> (!cs_n_o && !wr_n_o));

  // R5: data moves only with a falling clock or an abort
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(d_o) |-> ($fell(cclk_o) || fail_o));

  // R9: on a normal finish select is released one cycle ahead of write
  p_cs_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n_o) && !fail_o) |-> !wr_n_o ##1 wr_n_o);

  // R9: success reported with the port released and never together with a failure
  p_ok_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (!fail_o && cs_n_o && wr_n_o && prog_n_o));

  // R10: ready only while selected, clock high, init high and done low
  p_ready_ctx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (!cs_n_o && !wr_n_o && cclk_o && prog_n_o && init_n_i && !done_i));

  // R11: abort releases every strobe and clears the bus
  p_abort_safe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (prog_n_o && cs_n_o && wr_n_o && cclk_o && d_o == '0));

  // R11: failure is a single-cycle pulse
  p_fail_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);
endmodule

bind fpga_cfg_loader cfg_ld_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prog_n_o  (prog_n_o),
  .cs_n_o    (cs_n_o),
  .wr_n_o    (wr_n_o),
  .cclk_o    (cclk_o),
  .d_o       (d_o),
  .ok_o      (ok_o),
  .fail_o    (fail_o),
  .s_ready_o (s_ready_o),
  .init_n_i  (init_n_i),
  .done_i    (done_i)
);

// File: tb/sim_fpga_cfg_loader.sv
`timescale 1ns/1ps
module sim_fpga_cfg_loader;
  localparam int P_PROG = 4, P_ILO = 10, P_IHI = 12, P_SET = 5, P_HALF = 2, P_BSY = 6, P_DONE = 8;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] nbytes_i = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic init_n_i = 1'b1, busy_i = 1'b0, done_i = 1'b0;
  logic s_ready_o, prog_n_o, cs_n_o, wr_n_o, cclk_o, ok_o, fail_o;
  logic [7:0] d_o;
  logic [2:0] reason_o;
  logic [CW-1:0] fail_idx_o;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  fpga_cfg_loader #(
    .DW(8), .CNT_W(CW), .PROG_CYC(P_PROG), .INIT_LO_TMO(P_ILO), .INIT_HI_TMO(P_IHI),
    .SETTLE_CYC(P_SET), .CCLK_HALF(P_HALF), .BUSY_CHECK(1'b1), .BUSY_TMO(P_BSY), .DONE_TMO(P_DONE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .nbytes_i(nbytes_i),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready_o),
    .prog_n_o(prog_n_o), .cs_n_o(cs_n_o), .wr_n_o(wr_n_o), .cclk_o(cclk_o), .d_o(d_o),
    .init_n_i(init_n_i), .busy_i(busy_i), .done_i(done_i),
    .ok_o(ok_o), .fail_o(fail_o), .reason_o(reason_o), .fail_idx_o(fail_idx_o)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- byte source ----------------
  byte unsigned src_q[$];
  bit  gap_en = 0;
  bit  acc_flag = 0;
  int  acc_total = 0;
  int  gc = 0;

  always @(posedge clk) begin
    acc_flag <= s_valid && s_ready_o;
    if (s_valid && s_ready_o) acc_total <= acc_total + 1;
  end

  always @(negedge clk) begin
    if (s_valid && acc_flag) begin
      void'(src_q.pop_front());
      s_valid = 1'b0;
    end
    gc++;
    if (!s_valid && src_q.size() > 0 && !(gap_en && (gc % 3 == 0))) begin
      s_valid = 1'b1;
      s_data  = src_q[0];
    end
  end

  // ---------------- behavioural reference ----------------
  localparam int M_IDLE = 0, M_PGM = 1, M_WLO = 2, M_WHI = 3, M_SET = 4, M_BYTE = 5,
                 M_LOW = 6, M_HIGH = 7, M_BSY = 8, M_CSOFF = 9, M_POLL = 10;
  int ph = M_IDLE, el = 0, m_cnt = 0, m_nb = 0;
  bit e_prog = 1, e_cs = 1, e_wr = 1, e_cclk = 1, e_ok = 0, e_fail = 0;
  int e_d = 0, e_rsn = 0, e_idx = 0;

  always @(posedge clk or negedge rst_n) begin
    int nph, code;
    if (!rst_n) begin
      ph = M_IDLE; el = 0; m_cnt = 0; m_nb = 0;
      e_prog = 1; e_cs = 1; e_wr = 1; e_cclk = 1; e_ok = 0; e_fail = 0;
      e_d = 0; e_rsn = 0; e_idx = 0;
    end else begin
      nph = ph; code = 0; e_ok = 0; e_fail = 0;
      case (ph)
        M_IDLE: if (start_i) begin m_nb = nbytes_i; m_cnt = 0; e_prog = 0; nph = M_PGM; end
        M_PGM:  if (el == P_PROG - 1) nph = M_WLO;
        M_WLO:  if (!init_n_i) begin e_prog = 1; e_cclk = 1; nph = M_WHI; end
                else if (el == P_ILO - 1) code = 1;
        M_WHI:  if (init_n_i) begin e_cs = 0; e_wr = 0; nph = M_SET; end
                else if (el == P_IHI - 1) code = 2;
        M_SET:  if (el == P_SET - 1) nph = M_BYTE;
        M_BYTE: if (m_cnt == m_nb || done_i) begin e_cs = 1; nph = M_CSOFF; end
                else if (!init_n_i) begin code = 3; e_idx = m_cnt; end
                else if (s_valid) begin e_d = s_data; e_cclk = 0; m_cnt++; nph = M_LOW; end
        M_LOW:  if (el == P_HALF - 1) begin e_cclk = 1; nph = M_HIGH; end
        M_HIGH: if (el == P_HALF - 1) nph = M_BSY;
        M_BSY:  if (!busy_i) nph = M_BYTE;
                else if (el == P_BSY - 1) code = 4;
        M_CSOFF: begin e_wr = 1; nph = M_POLL; end
        M_POLL: if (done_i && init_n_i) begin e_ok = 1; nph = M_IDLE; end
                else if (el == P_DONE - 1) code = 5;
        default: nph = M_IDLE;
      endcase
      if (code != 0) begin
        e_prog = 1; e_cs = 1; e_wr = 1; e_cclk = 1; e_d = 0;
        e_fail = 1; e_rsn = code; nph = M_IDLE;
      end
      el = (nph == ph) ? el + 1 : 0;
      ph = nph;
    end
  end

  // cycle-by-cycle comparison, sampled 1 ns after the active edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2",  "prog_n_o",   prog_n_o,   e_prog);
      chk("R4",  "cs_n_o",     cs_n_o,     e_cs);
      chk("R9",  "wr_n_o",     wr_n_o,     e_wr);
      chk("R5",  "cclk_o",     cclk_o,     e_cclk);
      chk("R5",  "d_o",        d_o,        e_d);
      chk("R10", "s_ready_o",  s_ready_o,
          (ph == M_BYTE) && (m_cnt != m_nb) && !done_i && init_n_i);
      chk("R9",  "ok_o",       ok_o,       e_ok);
      chk("R11", "fail_o",     fail_o,     e_fail);
      chk("R11", "reason_o",   reason_o,   e_rsn);
      chk("R7",  "fail_idx_o", fail_idx_o, e_idx);
    end
  end

  // ---------------- scenario driver ----------------
  task automatic run(input int nb, input int lo_d, input int hi_d, input int err_at,
                     input int done_at, input int bmode, input bit fin_done, input bit gaps,
                     input bit poke, output bit r_ok, output int r_rsn, output int r_idx,
                     output int r_acc);
    int tl = 0, th = 0, bc = 0, bz = 0, fc = 0, a0;
    bit pc, rel = 0, sel = 0, f_e = 0, f_d = 0, poked = 0;
    @(negedge clk);
    gap_en = gaps;
    for (int i = 0; i < nb; i++) src_q.push_back(8'(8'hA5 ^ (i * 37 + nb)));
    a0 = acc_total;
    start_i = 1'b1; nbytes_i = CW'(nb);
    @(negedge clk);
    start_i = 1'b0; nbytes_i = CW'(nb + 3);
    pc = cclk_o;
    while (!(ok_o || fail_o)) begin
      start_i = 1'b0;
      if (!prog_n_o) begin
        if (tl == lo_d) init_n_i = 1'b0;
        tl++;
        rel = 1;
      end else if (rel && !sel) begin
        if (th == hi_d) init_n_i = 1'b1;
        th++;
      end
      if (!cs_n_o) sel = 1;
      if (cclk_o && !pc) begin
        bc++;
        if (bmode == 1) begin busy_i = 1'b1; bz = 4; end
        if (bmode == 2) busy_i = 1'b1;
      end else if (bz > 0) begin
        bz--;
        if (bz == 0) busy_i = 1'b0;
      end
      pc = cclk_o;
      if (!cs_n_o && !f_e && err_at >= 0 && bc == err_at) begin init_n_i = 1'b0; f_e = 1; end
      if (!cs_n_o && !f_d && done_at >= 0 && bc == done_at) begin done_i = 1'b1; f_d = 1; end
      if (sel && cs_n_o && fin_done) begin
        fc++;
        if (fc == 3) done_i = 1'b1;
      end
      if (poke && bc == 1 && !poked) begin start_i = 1'b1; nbytes_i = CW'(9); poked = 1; end
      @(negedge clk);
    end
    r_ok = ok_o; r_rsn = int'(reason_o); r_idx = int'(fail_idx_o);
    @(negedge clk);
    r_acc = acc_total - a0;
    start_i = 1'b0; init_n_i = 1'b1; done_i = 1'b0; busy_i = 1'b0;
    src_q.delete(); s_valid = 1'b0; gap_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit ok; int rsn, idx, acc;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "prog_n_o",  prog_n_o,  1);
    chk("R1", "cs_n_o",    cs_n_o,    1);
    chk("R1", "wr_n_o",    wr_n_o,    1);
    chk("R1", "cclk_o",    cclk_o,    1);
    chk("R1", "s_ready_o", s_ready_o, 0);
    chk("R1", "ok_fail",   {ok_o, fail_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // normal load, steady stream
    run(4, 3, 5, -1, -1, 0, 1, 0, 0, ok, rsn, idx, acc);
    chk("R9", "normal ok", ok, 1);
    chk("R10", "normal accepted", acc, 4);
    // normal load with stream gaps
    run(6, 1, 2, -1, -1, 0, 1, 1, 0, ok, rsn, idx, acc);
    chk("R9", "gapped ok", ok, 1);
    chk("R10", "gapped accepted", acc, 6);
    // init never falls
    run(3, -1, 0, -1, -1, 0, 1, 0, 0, ok, rsn, idx, acc);
    chk("R2", "init-assert reason", rsn, 1);
    chk("R2", "init-assert accepted", acc, 0);
    // init never returns high
    run(3, 2, -1, -1, -1, 0, 1, 0, 0, ok, rsn, idx, acc);
    chk("R3", "init-release reason", rsn, 2);
    // init drops after two bytes
    run(5, 2, 3, 2, -1, 0, 1, 0, 0, ok, rsn, idx, acc);
    chk("R7", "data error reason", rsn, 3);
    chk("R7", "data error index", idx, 2);
    chk("R7", "data error accepted", acc, 2);
    // done rises early
    run(5, 2, 3, -1, 2, 0, 0, 0, 0, ok, rsn, idx, acc);
    chk("R6", "early done ok", ok, 1);
    chk("R6", "early done accepted", acc, 2);
    // busy stuck high
    run(3, 2, 3, -1, -1, 2, 1, 0, 0, ok, rsn, idx, acc);
    chk("R8", "busy reason", rsn, 4);
    chk("R8", "busy accepted", acc, 1);
    // short busy stalls
    run(3, 2, 3, -1, -1, 1, 1, 1, 0, ok, rsn, idx, acc);
    chk("R8", "stall ok", ok, 1);
    chk("R8", "stall accepted", acc, 3);
    // done never rises
    run(2, 2, 3, -1, -1, 0, 0, 0, 0, ok, rsn, idx, acc);
    chk("R9", "completion reason", rsn, 5);
    // zero-length load
    run(0, 2, 3, -1, -1, 0, 1, 0, 0, ok, rsn, idx, acc);
    chk("R9", "zero-length ok", ok, 1);
    chk("R10", "zero-length accepted", acc, 0);
    // start poked mid-load with a new count
    run(3, 2, 3, -1, -1, 0, 1, 0, 1, ok, rsn, idx, acc);
    chk("R12", "poked ok", ok, 1);
    chk("R12", "poked accepted", acc, 3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule